// File: doc/BRIEF.md
# Six-Channel Interval Timer Bank

This block holds six independent down-counters that share one small register window. Software programs each channel with an interval, picks one of four clock-enable sources and a power-of-two divider, and then starts the channel in either a repeating or a one-time mode. Each time a channel expires it raises its own status flag. That flag reaches the channel's interrupt line only when the matching enable bit is set. Software clears the flags by writing ones to them.

The clock sources arrive as one-cycle enable pulses (`src_tick_i`) in the block's clock domain. The parameter `SRC_PRESENT` marks which of the four sources exist. Selecting a missing source is treated as a configuration error, and the channel keeps running at the rate it had before.

Top module: `itb_timer_bank`

## Requirements
- R1: After reset, the interrupt enable, status, interval and count registers read 0, every control register reads 0x04 (source 1, divide by 1, stopped), and all interrupt lines are low.
- R2: Decoded byte addresses are as follows: 0x00 is interrupt enable and 0x04 is interrupt status. Channel k (0..5) occupies slot 0x10*(k+1), with control at +0x0, interval at +0x4 and count at +0x8. Only address bits [7:0] decode, and bits above them must be 0. Any other address reads 0, and a write to it changes nothing.
- R3: Control fields are: bit 0 run, bit 1 reload, bits [3:2] source, bits [6:4] exponent N, bit 7 single-shot. A control write with bit 1 set copies the interval into the count at that clock edge. Without bit 1, the count is left as it was.
- R4: A running channel takes one count step per 2^N pulses of its selected source. Every control write restarts the divider.
- R5: A control write that selects a source whose `SRC_PRESENT` bit is 0 still stores the written value. The channel, however, keeps its previous source and exponent.
- R6: A count step taken when the count is 0 or 1 is an expiry. In periodic mode (bit 7 = 0) the count then reloads from the interval. Any other step decrements the count by one.
- R7: On expiry in single-shot mode, the count becomes 0 and hardware clears control bit 0. The channel then stays stopped.
- R8: Expiry sets the channel's status bit. A write to status clears each bit written as 1. When an expiry and a clear meet on the same edge, the bit stays set.
- R9: Each interrupt line is high exactly when both its status bit and its enable bit are 1.
- R10: The count register returns the live counter value. Writes to the count offset have no effect. An interval write does not change the current count.
- R11: A stopped channel holds its count, whatever the source pulses do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 4 | Clock-enable pulses of the four sources |
| addr_i | input | 10 | Register byte address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data of the addressed register (combinational) |
| irq_o | output | 6 | Per-channel interrupt lines |

## Verification
The hardest case to reach from the ports is an expiry that lands on the same edge as a status write clearing that bit. The same is true of a single-shot expiry that has to be seen to disarm the channel. The stimulus reaches the first case by programming an interval of 1 on the always-pulsing source, so that the expiry falls on the very next edge, and issuing the clear in that cycle. A long random phase uses small intervals and random source pulses, and a cycle model in the bench tracks every register, so such collisions and invalid-source selections recur many times.

// File: rtl/itb_pkg.sv
package itb_pkg;

  localparam int CTL_W   = 8;
  localparam int SRC_N   = 4;
  localparam int SRC_W   = 2;
  localparam int EXP_W   = 3;
  localparam int PC_W    = (1 << EXP_W) - 1;
  localparam int SLOT_W  = 4;

  localparam int RUN_BIT = 0;
  localparam int RLD_BIT = 1;
  localparam int SRC_LSB = 2;
  localparam int EXP_LSB = 4;
  localparam int ONE_BIT = 7;

  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_INTV = 2'd1,
    FLD_CNT  = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;

  typedef struct packed {
    logic              hit_ien;
    logic              hit_sts;
    logic              hit_ch;
    logic [SLOT_W-1:0] ch;
    fld_e              fld;
  } dec_t;

  // Divider terminal value for exponent e: 2^e - 1
  function automatic logic [PC_W-1:0] presc_limit(input logic [EXP_W-1:0] e);
    logic [PC_W:0] one;
    one = (PC_W+1)'(1);
    return PC_W'((one << e) - one);
  endfunction

  // Field selected by the low nibble of a channel slot address
  function automatic fld_e field_of(input logic [3:0] lo);
    case (lo)
      4'h0:    return FLD_CTRL;
      4'h4:    return FLD_INTV;
      4'h8:    return FLD_CNT;
      default: return FLD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/itb_regdec.sv
module itb_regdec
  import itb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NUM_CH = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);

  logic              upper_ok;
  logic [SLOT_W-1:0] slot;
  fld_e              fld;
  logic              slot_ok;

  assign upper_ok = (addr_i[ADDR_W-1:8] == '0);
  assign slot     = addr_i[7:4];
  assign fld      = field_of(addr_i[3:0]);
  assign slot_ok  = (slot >= SLOT_W'(1)) && (slot <= SLOT_W'(NUM_CH));

  always_comb begin
    dec_o         = '0;
    dec_o.fld     = FLD_NONE;
    dec_o.hit_ien = upper_ok && (addr_i[7:0] == 8'h00);
    dec_o.hit_sts = upper_ok && (addr_i[7:0] == 8'h04);
    if (upper_ok && slot_ok && (fld != FLD_NONE)) begin
      dec_o.hit_ch = 1'b1;
      dec_o.ch     = slot - SLOT_W'(1);
      dec_o.fld    = fld;
    end
  end

endmodule

// File: rtl/itb_prescaler.sv
module itb_prescaler
  import itb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             step_o
);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] lim;
  logic            wrap;

  assign lim    = presc_limit(exp_i);
  assign wrap   = (pc_q == lim);
  assign step_o = run_i & tick_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (restart_i) begin
      pc_q <= '0;
    end else if (run_i && tick_i) begin
      pc_q <= wrap ? '0 : pc_q + PC_W'(1);
    end
  end

  AST_DIV_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni) restart_i |=> (pc_q == '0)); // R4

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (!restart_i && !tick_i) |=> $stable(pc_q)); // R4

endmodule

// File: rtl/itb_channel.sv
module itb_channel
  import itb_pkg::*;
#(
  parameter int               CNT_W       = 32,
  parameter logic [SRC_N-1:0] SRC_PRESENT = 4'b1011,
  parameter logic [CTL_W-1:0] DEF_CTRL    = 8'h04
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             intv_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [SRC_N-1:0] src_tick_i,
  output logic [CTL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0] intv_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CTL_W-1:0] ctrl_q;
  logic [CNT_W-1:0] intv_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SRC_W-1:0] act_src_q;
  logic [EXP_W-1:0] act_exp_q;

  logic [SRC_W-1:0] new_src;
  logic [EXP_W-1:0] new_exp;
  logic             src_ok;
  logic             step;
  logic             at_end;
  logic             single;

  function automatic logic near_zero(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  assign new_src  = wdata_i[SRC_LSB +: SRC_W];
  assign new_exp  = wdata_i[EXP_LSB +: EXP_W];
  assign src_ok   = SRC_PRESENT[new_src];
  assign single   = ctrl_q[ONE_BIT];
  assign at_end   = near_zero(cnt_q);
  assign expire_o = step & at_end;

  itb_prescaler u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (ctrl_we_i),
    .run_i     (ctrl_q[RUN_BIT] & ~ctrl_we_i),
    .tick_i    (src_tick_i[act_src_q]),
    .exp_i     (act_exp_q),
    .step_o    (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= DEF_CTRL;
      act_src_q <= DEF_CTRL[SRC_LSB +: SRC_W];
      act_exp_q <= DEF_CTRL[EXP_LSB +: EXP_W];
      intv_q    <= '0;
      cnt_q     <= '0;
    end else begin
      if (intv_we_i) begin
        intv_q <= wdata_i;
      end
      if (ctrl_we_i) begin
        ctrl_q <= wdata_i[CTL_W-1:0];
        if (src_ok) begin
          act_src_q <= new_src;
          act_exp_q <= new_exp;
        end
        if (wdata_i[RLD_BIT]) begin
          cnt_q <= intv_q;
        end
      end else if (step) begin
        if (at_end) begin
          if (single) begin
            cnt_q           <= '0;
            ctrl_q[RUN_BIT] <= 1'b0;
          end else begin
            cnt_q <= intv_q;
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign intv_o = intv_q;
  assign cnt_o  = cnt_q;

  AST_RELOAD_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni) (ctrl_we_i && wdata_i[RLD_BIT]) |=> (cnt_q == $past(intv_q))); // R3

  AST_BAD_SRC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni) (ctrl_we_i && !src_ok) |=> ($stable(act_src_q) && $stable(act_exp_q))); // R5

  AST_PERIODIC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni) (expire_o && !single) |=> (cnt_q == $past(intv_q))); // R6

  AST_ONESHOT_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni) (expire_o && single) |=> (!ctrl_q[RUN_BIT] && cnt_q == '0)); // R7

  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (!ctrl_q[RUN_BIT] && !ctrl_we_i) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/itb_irq.sv
module itb_irq #(
  parameter int NUM_CH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ien_we_i,
  input  logic              sts_we_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic [NUM_CH-1:0] expire_i,
  output logic [NUM_CH-1:0] ien_o,
  output logic [NUM_CH-1:0] sts_o,
  output logic [NUM_CH-1:0] irq_o
);

  logic [NUM_CH-1:0] ien_q;
  logic [NUM_CH-1:0] sts_q;
  logic [NUM_CH-1:0] clr_mask;

  assign clr_mask = sts_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      sts_q <= '0;
    end else begin
      if (ien_we_i) begin
        ien_q <= wdata_i;
      end
      sts_q <= (sts_q & ~clr_mask) | expire_i;
    end
  end

  assign ien_o = ien_q;
  assign sts_o = sts_q;
  assign irq_o = sts_q & ien_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_EXPIRE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni) expire_i[i] |=> sts_q[i]); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni) (sts_we_i && wdata_i[i] && !expire_i[i]) |=> !sts_q[i]); // R8
    AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) (sts_q[i] && !sts_we_i) |=> sts_q[i]); // R8
  end

endmodule

// File: rtl/itb_timer_bank.sv
module itb_timer_bank
  import itb_pkg::*;
#(
  parameter int               ADDR_W      = 10,
  parameter int               DATA_W      = 32,
  parameter int               NUM_CH      = 6,
  parameter logic [SRC_N-1:0] SRC_PRESENT = 4'b1011,
  parameter logic [CTL_W-1:0] DEF_CTRL    = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_N-1:0]  src_tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_CH-1:0] irq_o
);

  dec_t dec;

  logic [CTL_W-1:0]  ch_ctrl [NUM_CH];
  logic [DATA_W-1:0] ch_intv [NUM_CH];
  logic [DATA_W-1:0] ch_cnt  [NUM_CH];
  logic [NUM_CH-1:0] expire;
  logic [NUM_CH-1:0] ien;
  logic [NUM_CH-1:0] sts;

  itb_regdec #(
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH)
  ) u_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = wr_en_i && dec.hit_ch && (dec.ch == SLOT_W'(i));

    itb_channel #(
      .CNT_W       (DATA_W),
      .SRC_PRESENT (SRC_PRESENT),
      .DEF_CTRL    (DEF_CTRL)
    ) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctrl_we_i  (sel && (dec.fld == FLD_CTRL)),
      .intv_we_i  (sel && (dec.fld == FLD_INTV)),
      .wdata_i    (wr_data_i),
      .src_tick_i (src_tick_i),
      .ctrl_o     (ch_ctrl[i]),
      .intv_o     (ch_intv[i]),
      .cnt_o      (ch_cnt[i]),
      .expire_o   (expire[i])
    );
  end

  itb_irq #(
    .NUM_CH (NUM_CH)
  ) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ien_we_i (wr_en_i && dec.hit_ien),
    .sts_we_i (wr_en_i && dec.hit_sts),
    .wdata_i  (wr_data_i[NUM_CH-1:0]),
    .expire_i (expire),
    .ien_o    (ien),
    .sts_o    (sts),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (dec.hit_ien) begin
      rd_data_o = DATA_W'(ien);
    end else if (dec.hit_sts) begin
      rd_data_o = DATA_W'(sts);
    end else if (dec.hit_ch) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (dec.ch == SLOT_W'(i)) begin
          case (dec.fld)
            FLD_CTRL: rd_data_o = DATA_W'(ch_ctrl[i]);
            FLD_INTV: rd_data_o = ch_intv[i];
            FLD_CNT:  rd_data_o = ch_cnt[i];
            default:  rd_data_o = '0;
          endcase
        end
      end
    end
  end

  AST_DECODE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0({dec.hit_ien, dec.hit_sts, dec.hit_ch})); // R2

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni) ((irq_o & ~(sts & ien)) == '0)); // R9

endmodule

// File: tb/itb_timer_bank_test.sv
module itb_timer_bank_test;

  localparam int         NCH     = 6;
  localparam logic [3:0] PRESENT = 4'b1011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic [9:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [5:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  itb_timer_bank #(.SRC_PRESENT(PRESENT)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .src_tick_i (src_tick),
    .addr_i     (addr),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .irq_o      (irq)
  );

  // Cycle model built from the requirements
  logic [7:0]  m_ctrl [NCH];
  logic [31:0] m_intv [NCH];
  logic [31:0] m_cnt  [NCH];
  logic [1:0]  m_src  [NCH];
  logic [2:0]  m_exp  [NCH];
  int          m_pc   [NCH];
  logic [5:0]  m_ien;
  logic [5:0]  m_sts;

  task automatic m_reset();
    for (int k = 0; k < NCH; k++) begin
      m_ctrl[k] = 8'h04; m_intv[k] = 0; m_cnt[k] = 0;
      m_src[k] = 2'd1; m_exp[k] = 3'd0; m_pc[k] = 0;
    end
    m_ien = 0; m_sts = 0;
  endtask

  function automatic logic [31:0] m_read(input logic [9:0] a);
    int s;
    s = int'(a[7:4]);
    if (a[9:8] != 2'b00) return 0;
    if (a[7:0] == 8'h00) return {26'd0, m_ien};
    if (a[7:0] == 8'h04) return {26'd0, m_sts};
    if (s < 1 || s > NCH) return 0;
    case (a[3:0])
      4'h0:    return {24'd0, m_ctrl[s-1]};
      4'h4:    return m_intv[s-1];
      4'h8:    return m_cnt[s-1];
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [9:0] a);
    if (a[9:8] != 2'b00) return "R2";
    if (a[7:0] == 8'h00) return "R9";
    if (a[7:0] == 8'h04) return "R8";
    if (a[7:4] < 4'd1 || a[7:4] > 4'd6) return "R2";
    case (a[3:0])
      4'h0:    return "R7";
      4'h4:    return "R10";
      4'h8:    return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic m_advance(input bit w, input logic [9:0] a, input logic [31:0] d,
                           input logic [3:0] t);
    logic [5:0] fired;
    bit ok;
    int s;
    fired = 0;
    ok = w && (a[9:8] == 2'b00);
    s = int'(a[7:4]);
    for (int k = 0; k < NCH; k++) begin
      bit cw;
      bit iw;
      logic [31:0] old_intv;
      cw = ok && (s == k + 1) && (a[3:0] == 4'h0);
      iw = ok && (s == k + 1) && (a[3:0] == 4'h4);
      old_intv = m_intv[k];
      if (cw) begin
        m_ctrl[k] = d[7:0];
        if (PRESENT[d[3:2]]) begin
          m_src[k] = d[3:2];
          m_exp[k] = d[6:4];
        end
        m_pc[k] = 0;
        if (d[1]) m_cnt[k] = old_intv;
      end else if (m_ctrl[k][0] && t[m_src[k]]) begin
        if (m_pc[k] == (1 << m_exp[k]) - 1) begin
          m_pc[k] = 0;
          if (m_cnt[k] <= 1) begin
            fired[k] = 1'b1;
            if (m_ctrl[k][7]) begin
              m_cnt[k] = 0;
              m_ctrl[k][0] = 1'b0;
            end else begin
              m_cnt[k] = old_intv;
            end
          end else begin
            m_cnt[k] = m_cnt[k] - 1;
          end
        end else begin
          m_pc[k] = m_pc[k] + 1;
        end
      end
      if (iw) m_intv[k] = d;
    end
    if (ok && a[7:0] == 8'h00) m_ien = d[5:0];
    if (ok && a[7:0] == 8'h04) m_sts = (m_sts & ~d[5:0]) | fired;
    else m_sts = m_sts | fired;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // One clock cycle: drive at the falling edge, compare at the next falling edge
  task automatic step(input bit w, input logic [9:0] a, input logic [31:0] d,
                      input logic [3:0] t);
    wr_en = w; addr = a; wr_data = d; src_tick = t;
    m_advance(w, a, d, t);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check(tag_of(a), rd_data, m_read(a));
    check("R9 irq", {26'd0, irq}, {26'd0, m_ien & m_sts});
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    step(1'b1, a, d, 4'b0001);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, addr, 32'd0, 4'b0001);
  endtask

  task automatic peek(input logic [9:0] a, input logic [31:0] exp, input string tag);
    wr_en = 1'b0; addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired before the run ended (all requirements)");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_reset();
    #1;

    // R1 reset values
    peek(10'h000, 0, "R1 enable");
    peek(10'h004, 0, "R1 status");
    peek(10'h010, 32'h04, "R1 ctrl ch0");
    peek(10'h060, 32'h04, "R1 ctrl ch5");
    peek(10'h014, 0, "R1 interval");
    peek(10'h018, 0, "R1 count");
    check("R1 irq", {26'd0, irq}, 0);

    // R2 undecoded addresses
    wr(10'h100, 32'h3F);
    peek(10'h000, 0, "R2 alias write ignored");
    peek(10'h00C, 0, "R2 hole read");
    peek(10'h070, 0, "R2 slot beyond channels");
    wr(10'h074, 32'hFF);
    peek(10'h01C, 0, "R2 bad field read");

    // R3 reload bit
    wr(10'h054, 32'd7);
    wr(10'h050, 32'h00);
    peek(10'h058, 0, "R3 no reload");
    wr(10'h050, 32'h02);
    peek(10'h058, 7, "R3 reload copies interval");

    // R4 divide by 4
    wr(10'h014, 32'd10);
    wr(10'h010, 32'h23);
    idle(8);
    peek(10'h018, 8, "R4 divided count");

    // R11 stopped channel
    wr(10'h010, 32'h20);
    idle(5);
    peek(10'h018, 8, "R11 hold");

    // R10 count write ignored, interval write leaves count
    wr(10'h018, 32'h55);
    peek(10'h018, 8, "R10 count write");
    wr(10'h014, 32'h99);
    peek(10'h018, 8, "R10 interval write");
    peek(10'h014, 32'h99, "R10 interval stored");

    // R6 periodic, R9 irq
    wr(10'h000, 32'h02);
    wr(10'h024, 32'd3);
    wr(10'h020, 32'h03);
    idle(2);
    peek(10'h004, 0, "R6 not yet expired");
    idle(1);
    peek(10'h004, 32'h02, "R6 expiry flag");
    peek(10'h028, 3, "R6 periodic reload");
    check("R9 irq raised", {26'd0, irq}, 32'h02);

    // R8 clear, and set winning over clear
    wr(10'h020, 32'h00);
    wr(10'h004, 32'h02);
    peek(10'h004, 0, "R8 write one clears");
    check("R9 irq dropped", {26'd0, irq}, 0);
    wr(10'h044, 32'd1);
    wr(10'h040, 32'h03);
    wr(10'h004, 32'h08);
    peek(10'h004, 32'h08, "R8 set wins");
    wr(10'h040, 32'h00);
    wr(10'h004, 32'h08);
    peek(10'h004, 0, "R8 cleared after stop");

    // R7 single shot
    wr(10'h034, 32'd2);
    wr(10'h030, 32'h83);
    idle(2);
    peek(10'h030, 32'h82, "R7 run bit cleared");
    peek(10'h038, 0, "R7 count zero");
    peek(10'h004, 32'h04, "R7 flag set");
    wr(10'h004, 32'h04);
    idle(4);
    peek(10'h004, 0, "R7 no further expiry");

    // R5 absent source keeps previous rate
    wr(10'h044, 32'd5);
    wr(10'h040, 32'h1B);
    idle(2);
    peek(10'h048, 3, "R5 previous source kept");
    peek(10'h040, 32'h1B, "R5 value stored");
    wr(10'h040, 32'h00);

    // Random phase against the model
    for (int n = 0; n < 4000; n++) begin
      bit w;
      logic [9:0] a;
      logic [31:0] d;
      int ch;
      int pick;
      w = ($urandom_range(0, 9) < 3);
      ch = $urandom_range(1, 6);
      pick = $urandom_range(0, 9);
      case (pick)
        0:       a = 10'h000;
        1:       a = 10'h004;
        2, 3:    a = {2'b00, 4'(ch), 4'h0};
        4:       a = {2'b00, 4'(ch), 4'h4};
        5, 6, 7: a = {2'b00, 4'(ch), 4'h8};
        8:       a = {2'b00, 4'($urandom_range(7, 15)), 4'h4};
        default: a = 10'($urandom_range(0, 1023));
      endcase
      if (a[3:0] == 4'h4 && a[7:4] != 4'h0) d = $urandom_range(0, 12);
      else if (a[3:0] == 4'h0 && a[7:4] != 4'h0) d = {24'd0, 8'($urandom) & 8'b1011_1111};
      else d = $urandom;
      step(w, a, d, 4'($urandom));
    end

    finish_run();
  end

endmodule